// File: doc/BRIEF.md
# Register State Save Sequencer

This block writes the floating-point and SIMD register state of a processor core out to memory as a fixed 512-byte image. A start command carries the destination address and three mode flags:

- whether the core is in 16-bit addressing mode;
- whether the stack registers currently hold SIMD integer data;
- whether the SIMD control/status register and the vector registers are to be saved.

The engine then streams the image as 16-byte beats on a write port that uses a valid/ready handshake. The beats go out in ascending address order.

The engine reads the header registers, the eight 80-bit stack registers and the eight 128-bit vector registers from its inputs while it streams. It never modifies them. The core must hold these inputs stable from the start command until done. The engine compresses the 2-bit tags to one bit per physical register. It trims the pointer offsets according to the addressing mode, and it fills every reserved byte with zero. It does not look at pending floating-point exceptions.

The destination address is checked before anything is written. A destination that is not 16-byte aligned produces a one-cycle fault pulse and no write beat at all.

Top module: `regdump_engine`

## Requirements
- R1: A start accepted while idle with `dest_addr[3:0]` non-zero raises `fault` for exactly the next cycle. It issues no write beat and gives no `done`.
- R2: An aligned start makes `wr_valid` rise in the next cycle. Beat n is written at `dest_addr + 16*n`, and beats go out in ascending order. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. Byte k of a beat sits at `wr_data[8k+7:8k]`.
- R3: Beat 0 holds the header, with byte offsets as follows:
  - bytes 0-1: the control word;
  - bytes 2-3: the status word;
  - byte 5: zero;
  - bytes 6-7: `opcode[10:0]`, with the upper 5 bits zero;
  - bytes 8-11: the instruction pointer offset;
  - bytes 12-13: the instruction pointer selector;
  - bytes 14-15: zero.
- R4: Byte 4 is the compressed tag. Bit i covers register i in physical order, taken from `tag_word[2i+1:2i]`. The bit is 0 when that pair is 2'b11 (empty) and 1 for any other pair.
- R5: When `addr16_mode` is set at start, the upper 16 bits of both pointer offsets are written as zero. When it is clear, the full 32-bit offsets are written.
- R6: Beat 1 holds the following, with byte offsets:
  - bytes 16-19: the data pointer offset;
  - bytes 20-21: the data pointer selector;
  - bytes 22-23: zero;
  - bytes 24-27: the SIMD control/status register;
  - bytes 28-31: its writable-bit mask.
- R7: Beats 2..9 carry stack registers 0..7, each in the low 10 bytes of its slot, with the top 6 bytes zero. When `stk_int_mode` is set at start, bytes 8-9 of each slot are also zero.
- R8: Beats 10..17 carry vector registers 0..7 unchanged. Beats 18..31 (bytes 288-511) are all zero.
- R9: When `vec_save_en` is clear at start, beats 10..17 are not issued. The following beat is beat 18, so 24 beats are written in total. Bytes 24-31 of beat 1 are written as zero.
- R10: `done` is high for exactly one cycle, the cycle after the final beat is accepted. `busy` is high from the cycle after the start until that `done` cycle, inclusive.
- R11: A start seen while `busy` is high is ignored. It causes no fault and does not change the addresses or data of the save in progress.
- R12: After reset, `wr_valid`, `done`, `fault` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Save command, one cycle |
| dest_addr | input | AW | Byte address of the image |
| addr16_mode | input | 1 | 16-bit addressing mode flag |
| stk_int_mode | input | 1 | Stack registers hold SIMD integer data |
| vec_save_en | input | 1 | Save SIMD control/status and vector registers |
| ctl_word | input | 16 | Floating-point control word |
| sts_word | input | 16 | Floating-point status word |
| tag_word | input | 2*NSTK | Full 2-bit-per-register tag word |
| opcode | input | 16 | Last opcode (low 11 bits used) |
| ip_off | input | 32 | Instruction pointer offset |
| ip_sel | input | 16 | Instruction pointer selector |
| dp_off | input | 32 | Data pointer offset |
| dp_sel | input | 16 | Data pointer selector |
| vcsr | input | 32 | SIMD control/status register |
| vcsr_mask | input | 32 | Writable-bit mask of the SIMD control/status register |
| stk_regs | input | 80*NSTK | Stack registers, register i at bits [80i+79:80i] |
| vec_regs | input | 128*NVEC | Vector registers, register i at bits [128i+127:128i] |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write port accepts the beat |
| wr_addr | output | AW | Beat byte address |
| wr_data | output | 128 | Beat data, little-endian bytes |
| busy | output | 1 | Save in progress |
| done | output | 1 | Save complete pulse |
| fault | output | 1 | Misaligned destination pulse |

## Verification
Some properties are checked on every cycle:
- alignment of the beat addresses;
- beats holding their address and data during back-pressure;
- fault excluding any write, and a misaligned start always leading to a fault;
- done being a single cycle that follows an accepted beat;
- skipped vector beats never appearing;
- the zero padding of the opcode field and of the stack slots.

Other properties only the scenarios can show, against the bench's byte-level image model:
- the byte placement of each header field;
- the tag compression over distinct tag patterns;
- pointer trimming in 16-bit mode and the integer-mode padding;
- the ignored start in the middle of a save.

// File: rtl/regdump_pkg.sv
package regdump_pkg;

    localparam int IMG_BYTES  = 512;
    localparam int BEAT_BYTES = 16;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int ADDR_LSB   = $clog2(BEAT_BYTES);
    localparam int HDR_BEATS  = 2;
    localparam int STK_W      = 80;
    localparam int STK_LO_W   = 64;
    localparam int VEC_W      = 128;
    localparam int OPC_BITS   = 11;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RUN  = 2'd1,
        RD_DONE = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic addr16;
        logic intstk;
        logic vec_en;
    } rd_mode_t;

    typedef struct packed {
        logic [15:0] ctl;
        logic [15:0] sts;
        logic [15:0] opc;
        logic [31:0] ip_off;
        logic [15:0] ip_sel;
        logic [31:0] dp_off;
        logic [15:0] dp_sel;
        logic [31:0] vcsr;
        logic [31:0] vmask;
    } rd_hdr_t;

    function automatic logic [31:0] fmt_ptr(input logic [31:0] off, input logic addr16);
        fmt_ptr = addr16 ? {16'h0000, off[15:0]} : off;
    endfunction

    function automatic logic [15:0] fmt_opc(input logic [15:0] opc);
        fmt_opc = {{(16 - OPC_BITS){1'b0}}, opc[OPC_BITS-1:0]};
    endfunction

endpackage

// File: rtl/regdump_tagpack.sv
module regdump_tagpack #(
    parameter int NREG = 8
) (
    input  logic [2*NREG-1:0] tag_full,
    output logic [NREG-1:0]   tag_bits
);
    for (genvar g = 0; g < NREG; g++) begin : g_tag
        // empty (2'b11) maps to 0, any other class maps to 1
        assign tag_bits[g] = ~(&tag_full[2*g +: 2]);
    end
endmodule

// File: rtl/regdump_ctrl.sv
module regdump_ctrl
    import regdump_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NBEATS    = 32,
    parameter int BW        = 5,
    parameter int VEC_FIRST = 10,
    parameter int VEC_LAST  = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   dest_addr,
    input  rd_mode_t        mode_in,
    input  logic            wr_ready,
    output logic [BW-1:0]   beat_q,
    output logic [AW-1:0]   base_q,
    output rd_mode_t        mode_q,
    output logic            wr_valid,
    output logic            busy,
    output logic            done,
    output logic            fault
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(NBEATS - 1);
    localparam logic [BW-1:0] PRE_VEC   = BW'(VEC_FIRST - 1);
    localparam logic [BW-1:0] POST_VEC  = BW'(VEC_LAST + 1);

    rd_state_e     state_q;
    logic [BW-1:0] beat_nx;
    logic          misaligned;

    assign misaligned = (dest_addr[ADDR_LSB-1:0] != '0);

    always_comb begin
        if (!mode_q.vec_en && beat_q == PRE_VEC) begin
            beat_nx = POST_VEC;
        end else begin
            beat_nx = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mode_q  <= '0;
            fault   <= 1'b0;
        end else begin
            fault <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (start) begin
                        if (misaligned) begin
                            fault <= 1'b1;
                        end else begin
                            base_q  <= dest_addr;
                            mode_q  <= mode_in;
                            beat_q  <= '0;
                            state_q <= RD_RUN;
                        end
                    end
                end
                RD_RUN: begin
                    if (wr_ready) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= RD_DONE;
                        end else begin
                            beat_q <= beat_nx;
                        end
                    end
                end
                RD_DONE: state_q <= RD_IDLE;
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign wr_valid = (state_q == RD_RUN);
    assign done     = (state_q == RD_DONE);
    assign busy     = (state_q != RD_IDLE);
endmodule

// File: rtl/regdump_beatmux.sv
module regdump_beatmux
    import regdump_pkg::*;
#(
    parameter int NSTK      = 8,
    parameter int NVEC      = 8,
    parameter int BW        = 5,
    parameter int STK_FIRST = 2,
    parameter int VEC_FIRST = 10
) (
    input  logic [BW-1:0]        beat,
    input  rd_hdr_t              hdr,
    input  rd_mode_t             mode,
    input  logic [NSTK-1:0]      tag_bits,
    input  logic [NSTK*STK_W-1:0] stk_regs,
    input  logic [NVEC*VEC_W-1:0] vec_regs,
    output logic [BEAT_W-1:0]    data
);
    localparam int STK_PAD = BEAT_W - STK_W;
    localparam int STK_HI  = STK_W - STK_LO_W;

    logic [BEAT_W-1:0] stk_slot [NSTK];
    logic [BEAT_W-1:0] vec_slot [NVEC];
    logic [BEAT_W-1:0] hdr0, hdr1;
    logic [31:0]       vcsr_eff, vmask_eff;

    for (genvar g = 0; g < NSTK; g++) begin : g_stk
        logic [STK_HI-1:0] hi;
        assign hi = mode.intstk ? '0 : stk_regs[g*STK_W + STK_LO_W +: STK_HI];
        assign stk_slot[g] = {{STK_PAD{1'b0}}, hi, stk_regs[g*STK_W +: STK_LO_W]};
    end

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        assign vec_slot[g] = vec_regs[g*VEC_W +: VEC_W];
    end

    assign vcsr_eff  = mode.vec_en ? hdr.vcsr  : 32'h0;
    assign vmask_eff = mode.vec_en ? hdr.vmask : 32'h0;

    assign hdr0 = {16'h0000, hdr.ip_sel, fmt_ptr(hdr.ip_off, mode.addr16),
                   fmt_opc(hdr.opc), 8'h00, tag_bits, hdr.sts, hdr.ctl};
    assign hdr1 = {vmask_eff, vcsr_eff, 16'h0000, hdr.dp_sel,
                   fmt_ptr(hdr.dp_off, mode.addr16)};

    always_comb begin
        data = '0;
        if (beat == BW'(0)) begin
            data = hdr0;
        end else if (beat == BW'(1)) begin
            data = hdr1;
        end
        for (int i = 0; i < NSTK; i++) begin
            if (beat == BW'(STK_FIRST + i)) data = stk_slot[i];
        end
        for (int i = 0; i < NVEC; i++) begin
            if (beat == BW'(VEC_FIRST + i)) data = vec_slot[i];
        end
    end
endmodule

// File: rtl/regdump_engine.sv
module regdump_engine
    import regdump_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NSTK = 8,
    parameter int NVEC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [AW-1:0]        dest_addr,
    input  logic                 addr16_mode,
    input  logic                 stk_int_mode,
    input  logic                 vec_save_en,
    input  logic [15:0]          ctl_word,
    input  logic [15:0]          sts_word,
    input  logic [2*NSTK-1:0]    tag_word,
    input  logic [15:0]          opcode,
    input  logic [31:0]          ip_off,
    input  logic [15:0]          ip_sel,
    input  logic [31:0]          dp_off,
    input  logic [15:0]          dp_sel,
    input  logic [31:0]          vcsr,
    input  logic [31:0]          vcsr_mask,
    input  logic [NSTK*80-1:0]   stk_regs,
    input  logic [NVEC*128-1:0]  vec_regs,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [AW-1:0]        wr_addr,
    output logic [127:0]         wr_data,
    output logic                 busy,
    output logic                 done,
    output logic                 fault
);
    localparam int NBEATS    = IMG_BYTES / BEAT_BYTES;
    localparam int BW        = $clog2(NBEATS);
    localparam int STK_FIRST = HDR_BEATS;
    localparam int VEC_FIRST = STK_FIRST + NSTK;
    localparam int VEC_LAST  = VEC_FIRST + NVEC - 1;

    rd_mode_t        mode_in, mode_q;
    rd_hdr_t         hdr;
    logic [BW-1:0]   beat_q;
    logic [AW-1:0]   base_q;
    logic [NSTK-1:0] tag_bits;

    assign mode_in = '{addr16: addr16_mode, intstk: stk_int_mode, vec_en: vec_save_en};
    assign hdr = '{ctl: ctl_word, sts: sts_word, opc: opcode,
                   ip_off: ip_off, ip_sel: ip_sel, dp_off: dp_off, dp_sel: dp_sel,
                   vcsr: vcsr, vmask: vcsr_mask};

    regdump_tagpack #(.NREG(NSTK)) u_tag (
        .tag_full (tag_word),
        .tag_bits (tag_bits)
    );

    regdump_ctrl #(
        .AW(AW), .NBEATS(NBEATS), .BW(BW),
        .VEC_FIRST(VEC_FIRST), .VEC_LAST(VEC_LAST)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dest_addr (dest_addr),
        .mode_in   (mode_in),
        .wr_ready  (wr_ready),
        .beat_q    (beat_q),
        .base_q    (base_q),
        .mode_q    (mode_q),
        .wr_valid  (wr_valid),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

    regdump_beatmux #(
        .NSTK(NSTK), .NVEC(NVEC), .BW(BW),
        .STK_FIRST(STK_FIRST), .VEC_FIRST(VEC_FIRST)
    ) u_mux (
        .beat     (beat_q),
        .hdr      (hdr),
        .mode     (mode_q),
        .tag_bits (tag_bits),
        .stk_regs (stk_regs),
        .vec_regs (vec_regs),
        .data     (wr_data)
    );

    assign wr_addr = base_q + (AW'(beat_q) << ADDR_LSB);
endmodule

// File: rtl/regdump_checker.sv
module regdump_checker
    import regdump_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BW        = 5,
    parameter int STK_FIRST = 2,
    parameter int VEC_FIRST = 10,
    parameter int VEC_LAST  = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] dest_addr,
    input logic          busy,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [127:0]  wr_data,
    input logic          done,
    input logic          fault,
    input logic [BW-1:0] beat_q,
    input logic          vec_en_q
);
    p_misaligned_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && dest_addr[ADDR_LSB-1:0] != '0) |=> fault);

    p_fault_no_write_r1: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!wr_valid && !done && !busy));

    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[ADDR_LSB-1:0] == '0));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_opcode_pad_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && beat_q == '0) |-> (wr_data[63:48+OPC_BITS] == '0 && wr_data[47:40] == 8'h00));

    p_slot_pad_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && beat_q >= BW'(STK_FIRST) && beat_q < BW'(VEC_FIRST)) |-> (wr_data[127:80] == '0));

    p_skip_vec_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !vec_en_q) |-> !(beat_q >= BW'(VEC_FIRST) && beat_q <= BW'(VEC_LAST)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_valid && wr_ready));
endmodule

bind regdump_engine regdump_checker #(
    .AW(AW), .BW(BW), .STK_FIRST(STK_FIRST), .VEC_FIRST(VEC_FIRST), .VEC_LAST(VEC_LAST)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dest_addr (dest_addr),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .fault     (fault),
    .beat_q    (beat_q),
    .vec_en_q  (mode_q.vec_en)
);

// File: tb/regdump_engine_test.sv
module regdump_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NSTK = 8;
    localparam int NVEC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] dest_addr = '0;
    logic addr16_mode = 1'b0, stk_int_mode = 1'b0, vec_save_en = 1'b1;
    logic [15:0] ctl_word = '0, sts_word = '0, opcode = '0, ip_sel = '0, dp_sel = '0;
    logic [2*NSTK-1:0] tag_word = '0;
    logic [31:0] ip_off = '0, dp_off = '0, vcsr = '0, vcsr_mask = '0;
    logic [NSTK*80-1:0] stk_regs = '0;
    logic [NVEC*128-1:0] vec_regs = '0;
    logic wr_valid, wr_ready = 1'b1;
    logic [AW-1:0] wr_addr;
    logic [127:0] wr_data;
    logic busy, done, fault;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    bit finished = 0;

    // reference model state
    int phase = 0;              // 0 idle, 1 writing, 2 done cycle
    bit m_fault = 0;
    bit m_vec_en = 1;
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] q_addr [$];
    logic [127:0]  q_data [$];
    logic [7:0] img [0:511];

    regdump_engine #(.AW(AW), .NSTK(NSTK), .NVEC(NVEC)) uut (
        .clk(clk), .rst(rst), .start(start), .dest_addr(dest_addr),
        .addr16_mode(addr16_mode), .stk_int_mode(stk_int_mode), .vec_save_en(vec_save_en),
        .ctl_word(ctl_word), .sts_word(sts_word), .tag_word(tag_word), .opcode(opcode),
        .ip_off(ip_off), .ip_sel(ip_sel), .dp_off(dp_off), .dp_sel(dp_sel),
        .vcsr(vcsr), .vcsr_mask(vcsr_mask), .stk_regs(stk_regs), .vec_regs(vec_regs),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input int off, input int n, input logic [127:0] v);
        for (int k = 0; k < n; k++) img[off + k] = v[8*k +: 8];
    endtask

    // behavioural image per requirements R3..R9
    task automatic build_image();
        logic [7:0] tg;
        for (int i = 0; i < 512; i++) img[i] = 8'h00;
        for (int r = 0; r < NSTK; r++) tg[r] = (tag_word[2*r +: 2] == 2'b11) ? 1'b0 : 1'b1;
        put(0, 2, ctl_word);
        put(2, 2, sts_word);
        put(4, 1, tg);
        put(6, 2, opcode & 16'h07FF);
        put(8, 4, addr16_mode ? (ip_off & 32'hFFFF) : ip_off);
        put(12, 2, ip_sel);
        put(16, 4, addr16_mode ? (dp_off & 32'hFFFF) : dp_off);
        put(20, 2, dp_sel);
        if (vec_save_en) begin
            put(24, 4, vcsr);
            put(28, 4, vcsr_mask);
        end
        for (int r = 0; r < NSTK; r++) begin
            put(32 + 16*r, 8, stk_regs[80*r +: 64]);
            if (!stk_int_mode) put(40 + 16*r, 2, stk_regs[80*r + 64 +: 16]);
        end
        for (int r = 0; r < NVEC; r++) put(160 + 16*r, 16, vec_regs[128*r +: 128]);
        for (int b = 0; b < 32; b++) begin
            logic [127:0] d;
            if (!vec_save_en && b >= 10 && b <= 17) continue;
            for (int k = 0; k < 16; k++) d[8*k +: 8] = img[16*b + k];
            q_addr.push_back(dest_addr + AW'(16*b));
            q_data.push_back(d);
        end
    endtask

    always @(posedge clk) begin
        m_fault <= 1'b0;
        if (rst) begin
            phase = 0;
            q_addr.delete();
            q_data.delete();
        end else begin
            case (phase)
                1: if (wr_ready) begin
                       void'(q_addr.pop_front());
                       void'(q_data.pop_front());
                       if (q_addr.size() == 0) phase = 2;
                   end
                2: phase = 0;
                default: if (start) begin
                    if (dest_addr[3:0] != 4'h0) begin
                        m_fault <= 1'b1;
                    end else begin
                        m_base = dest_addr;
                        m_vec_en = vec_save_en;
                        build_image();
                        phase = 1;
                    end
                end
            endcase
        end
    end

    function automatic string data_req(input logic [AW-1:0] a);
        int b;
        b = int'((a - m_base) >> 4);
        if (b == 0) return "R3 R4 R5";
        if (b == 1) return m_vec_en ? "R5 R6" : "R6 R9";
        if (b < 10) return "R7";
        return m_vec_en ? "R8" : "R8 R9";
    endfunction

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(wr_valid === (phase == 1), "R2", "wr_valid", wr_valid, phase == 1);
            check(done === (phase == 2), "R10", "done", done, phase == 2);
            check(busy === (phase != 0), "R10 R11", "busy", busy, phase != 0);
            check(fault === m_fault, "R1 R11", "fault", fault, m_fault);
            if (phase == 1 && wr_valid === 1'b1) begin
                check(wr_addr === q_addr[0], m_vec_en ? "R2" : "R2 R9", "wr_addr",
                      wr_addr, q_addr[0]);
                check(wr_data === q_data[0], data_req(q_addr[0]), "wr_data",
                      wr_data, q_data[0]);
            end
        end
        case (ready_mode)
            0: wr_ready <= 1'b1;
            default: wr_ready <= ($urandom % 3) != 0;
        endcase
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic fill_regs(input logic [15:0] tags);
        ctl_word = 16'($urandom); sts_word = 16'($urandom); opcode = 16'hF800 | 16'($urandom);
        ip_off = $urandom | 32'h8000_0000; dp_off = $urandom | 32'h0001_0000;
        ip_sel = 16'($urandom); dp_sel = 16'($urandom);
        vcsr = $urandom; vcsr_mask = $urandom | 32'h1;
        tag_word = tags;
        for (int i = 0; i < NSTK*80/32 + 1; i++) stk_regs = {stk_regs[NSTK*80-33:0], 32'($urandom) | 32'h0101_0101};
        for (int i = 0; i < NVEC*4; i++) vec_regs = {vec_regs[NVEC*128-33:0], 32'($urandom) | 32'h1};
    endtask

    task automatic run_save(input logic [AW-1:0] a, input bit m16, input bit mint, input bit ven);
        @(negedge clk);
        dest_addr = a; addr16_mode = m16; stk_int_mode = mint; vec_save_en = ven;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        // R12: reset state
        check(wr_valid === 1'b0 && done === 1'b0 && fault === 1'b0 && busy === 1'b0,
              "R12", "outputs in reset", {wr_valid, done, fault, busy}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);

        fill_regs(16'hC0FF);
        run_save(32'h0000_1000, 1'b0, 1'b0, 1'b1);   // R2 R3 R4 full-width pointers

        ready_mode = 1;
        fill_regs(16'h0000);
        run_save(32'h0000_2F00, 1'b1, 1'b1, 1'b1);   // R5 R7 under back-pressure

        fill_regs(16'hFFFF);
        run_save(32'hFFFF_FF00, 1'b0, 1'b0, 1'b0);   // R9 skip vectors, address wrap

        ready_mode = 0;
        fill_regs(16'h3C96);
        run_save(32'h0000_4008, 1'b0, 1'b0, 1'b1);   // R1 misaligned
        run_save(32'h0000_4001, 1'b1, 1'b0, 1'b0);   // R1 misaligned, low bit

        // R11: start pulses during a save are ignored
        @(negedge clk);
        dest_addr = 32'h0000_5000; vec_save_en = 1'b1; addr16_mode = 1'b0; stk_int_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        dest_addr = 32'h0000_6004; start = 1'b1;
        @(negedge clk);
        dest_addr = 32'h0000_7000;
        repeat (5) @(negedge clk);
        start = 1'b0;
        dest_addr = 32'h0000_5000;
        while (phase != 0) @(negedge clk);
        repeat (2) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule